// File: doc/BRIEF.md
# Indirect Register Access Bridge over MDIO

This block is a management slave on a Clause 22 MDIO bus. It responds only to frames addressed to the PHY address on its strap input. Through a handful of 16-bit access registers, a station reaches a wider internal register space. The station first arms the bridge by writing a control value. It then loads a target address and, for a store, the data. Finally it writes a command word. For a fetch, the bridge places the internal value in a result register, and the station collects it with an ordinary MDIO read.

MDC and MDIO are sampled with the system clock through a synchronizer and detected as edges. The frame decoder shifts the serial stream in on MDC rising edges. On a read, the decoder shifts the reply out on MDC falling edges. A 64-word flop array stands in for the device behind the bridge, and its base offset in the internal space is a parameter.

Top module: `mgmt_indirect_bridge`

## Requirements
- R1: Only frames whose 5-bit PHY field equals `phy_addr_strap` have any effect. For any other frame the bridge never drives MDIO, and a read returns 0xFFFF through the pull-up.
- R2: A frame is accepted only after at least 32 consecutive ones of preamble. The frame is the start pattern 01, then the opcode (10 = read, 01 = write), the PHY field, the register field, two turnaround bits and 16 data bits, each field sent MSB first. A frame with a shorter preamble is ignored.
- R3: On a read, the bridge leaves MDIO released during both turnaround bits. It then drives D15 down to D0, changing the line only after MDC falling edges. It releases the line after the last data bit.
- R4: Register 31 (arm), register 23 (target address) and register 24 (store data) accept writes and read back the last value written.
- R5: Writing 0x0003 to register 21 while register 31 holds 0x000E stores register 24 into the internal word addressed by register 23.
- R6: Writing 0x0001 to register 21 while register 31 holds 0x000E copies the internal word addressed by register 23 into register 25.
- R7: A write to register 21 has no effect when register 31 does not hold 0x000E. It also has no effect when the written value is neither 0x0001 nor 0x0003.
- R8: The internal array covers the 64 addresses 0x0000–0x003F. A fetch from any other address returns 0x0000, and a store to any other address changes no word.
- R9: Register 25 keeps its value until the next accepted fetch command.
- R10: Reads of register 21 and of any register other than 23, 24, 25 and 31 return 0x0000.
- R11: After reset, MDIO is released and every access register and internal word is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the MDC rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| phy_addr_strap | input | 5 | PHY address this bridge answers to |
| mdc | input | 1 | Management clock from the station |
| mdio_i | input | 1 | MDIO line as seen at the pad |
| mdio_o | output | 1 | Value driven onto MDIO while enabled |
| mdio_oe | output | 1 | MDIO output enable, high only in the reply's data phase |

## Verification
The assertions check four things on every cycle. The output enable and the driven bit change only after a detected MDC falling edge. The output is enabled only for a frame whose PHY field matched. The result register holds still unless an armed fetch command arrives. Under this block's rules, a command write while the bridge is disarmed leaves the result register unchanged. The scenarios in the bench are needed to show the rest. These are the bit order of the reply, the release of the line during turnaround, and the rejection of short preambles and foreign PHY addresses. They also cover out-of-range stores and the aliasing of index bits, and the fact that an ignored store really leaves the array unchanged.

// File: rtl/mib_pkg.sv
`timescale 1ns/1ps
package mib_pkg;
   localparam int unsigned WORD_W  = 16;
   localparam int unsigned FIELD_W = 5;

   typedef logic [WORD_W-1:0]  word_t;
   typedef logic [FIELD_W-1:0] field_t;

   typedef enum logic [2:0] {
      FS_PRE, FS_START, FS_OP, FS_PHY, FS_REG, FS_TA, FS_DATA
   } frame_st_e;

   // access register numbers (the station's software depends on them)
   localparam field_t RA_CMD   = 5'd21;
   localparam field_t RA_ADDR  = 5'd23;
   localparam field_t RA_WDATA = 5'd24;
   localparam field_t RA_RDATA = 5'd25;
   localparam field_t RA_CTRL  = 5'd31;

   localparam word_t ARM_CODE  = 16'h000E;
   localparam word_t CMD_STORE = 16'h0003;
   localparam word_t CMD_FETCH = 16'h0001;
endpackage

// File: rtl/mib_sync.sv
`timescale 1ns/1ps
module mib_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic mdc,
   input  logic mdio_i,
   output logic mdc_rise,
   output logic mdc_fall,
   output logic mdio_s
);
   logic [STAGES-1:0] mdc_sh;
   logic [STAGES-1:0] dio_sh;
   logic              mdc_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_sh <= '0;
         dio_sh <= '1;
         mdc_d  <= 1'b0;
      end else begin
         mdc_sh <= {mdc_sh[STAGES-2:0], mdc};
         dio_sh <= {dio_sh[STAGES-2:0], mdio_i};
         mdc_d  <= mdc_sh[STAGES-1];
      end
   end

   assign mdc_rise = mdc_sh[STAGES-1] & ~mdc_d;
   assign mdc_fall = ~mdc_sh[STAGES-1] & mdc_d;
   assign mdio_s   = dio_sh[STAGES-1];
endmodule

// File: rtl/mib_frame.sv
`timescale 1ns/1ps
module mib_frame
   import mib_pkg::*;
#(
   parameter int unsigned PRE_MIN = 32
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   mdc_rise,
   input  logic   mdc_fall,
   input  logic   mdio_s,
   input  field_t phy_strap,
   input  word_t  rd_word,
   output field_t cur_reg,
   output logic   wr_stb,
   output word_t  wr_word,
   output logic   phy_hit,
   output logic   mdio_o,
   output logic   mdio_oe
);
   localparam int unsigned CNT_MAX = (PRE_MIN > WORD_W) ? PRE_MIN : WORD_W;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] PRE_LIM  = CNT_W'(PRE_MIN);
   localparam logic [CNT_W-1:0] FLD_LAST = CNT_W'(FIELD_W - 1);
   localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(WORD_W - 1);

   frame_st_e        st;
   logic [CNT_W-1:0] cnt;
   logic             op_hi;
   logic             op_rd;
   field_t           phy_sh;
   field_t           reg_sh;
   word_t            dat_sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= FS_PRE;
         cnt     <= '0;
         op_hi   <= 1'b0;
         op_rd   <= 1'b0;
         phy_sh  <= '0;
         reg_sh  <= '0;
         dat_sh  <= '0;
         phy_hit <= 1'b0;
         wr_stb  <= 1'b0;
      end else begin
         wr_stb <= 1'b0;
         if (mdc_rise) begin
            unique case (st)
               FS_PRE: begin
                  if (mdio_s) begin
                     if (cnt != PRE_LIM) cnt <= cnt + 1'b1;
                  end else if (cnt >= PRE_LIM) begin
                     st  <= FS_START;
                     cnt <= '0;
                  end else begin
                     cnt <= '0;
                  end
               end
               FS_START: begin
                  cnt <= '0;
                  st  <= mdio_s ? FS_OP : FS_PRE;
               end
               FS_OP: begin
                  if (cnt == '0) begin
                     op_hi <= mdio_s;
                     cnt   <= cnt + 1'b1;
                  end else begin
                     cnt   <= '0;
                     op_rd <= op_hi;
                     st    <= (op_hi ^ mdio_s) ? FS_PHY : FS_PRE;
                  end
               end
               FS_PHY: begin
                  phy_sh <= {phy_sh[FIELD_W-2:0], mdio_s};
                  if (cnt == FLD_LAST) begin
                     cnt <= '0;
                     st  <= FS_REG;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FS_REG: begin
                  reg_sh <= {reg_sh[FIELD_W-2:0], mdio_s};
                  if (cnt == FLD_LAST) begin
                     cnt     <= '0;
                     st      <= FS_TA;
                     phy_hit <= (phy_sh == phy_strap);
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               FS_TA: begin
                  if (cnt == '0) begin
                     cnt <= cnt + 1'b1;
                  end else begin
                     cnt    <= '0;
                     st     <= FS_DATA;
                     dat_sh <= op_rd ? rd_word : '0;
                  end
               end
               FS_DATA: begin
                  dat_sh <= {dat_sh[WORD_W-2:0], mdio_s};
                  if (cnt == DAT_LAST) begin
                     cnt    <= '0;
                     st     <= FS_PRE;
                     wr_stb <= ~op_rd & phy_hit;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
               default: begin
                  st  <= FS_PRE;
                  cnt <= '0;
               end
            endcase
         end
      end
   end

   // reply path: line changes only after a falling MDC edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdio_oe <= 1'b0;
         mdio_o  <= 1'b0;
      end else if (mdc_fall) begin
         mdio_oe <= (st == FS_DATA) & op_rd & phy_hit;
         mdio_o  <= ((st == FS_DATA) & op_rd & phy_hit) ? dat_sh[WORD_W-1] : 1'b0;
      end
   end

   assign cur_reg = reg_sh;
   assign wr_word = dat_sh;
endmodule

// File: rtl/mib_regs.sv
`timescale 1ns/1ps
module mib_regs
   import mib_pkg::*;
#(
   parameter int unsigned DEPTH = 64,
   parameter logic [15:0] BASE  = 16'h0000
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   wr_stb,
   input  field_t wr_reg,
   input  word_t  wr_word,
   input  field_t rd_reg,
   output word_t  rd_word,
   output word_t  ctrl_q,
   output word_t  rdata_q
);
   localparam int unsigned IDX_W   = $clog2(DEPTH);
   localparam word_t       DEPTH_W = word_t'(DEPTH);

   word_t              addr_q;
   word_t              wdata_q;
   word_t              offs;
   logic               in_rng;
   logic [IDX_W-1:0]   idx;
   logic               cmd_ok;
   logic               do_store;
   logic               do_fetch;
   word_t              cells [DEPTH];

   assign offs     = addr_q - BASE;
   assign in_rng   = offs < DEPTH_W;
   assign idx      = offs[IDX_W-1:0];
   assign cmd_ok   = wr_stb & (wr_reg == RA_CMD) & (ctrl_q == ARM_CODE);
   assign do_store = cmd_ok & (wr_word == CMD_STORE);
   assign do_fetch = cmd_ok & (wr_word == CMD_FETCH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (wr_stb) begin
         unique case (wr_reg)
            RA_CTRL:  ctrl_q  <= wr_word;
            RA_ADDR:  addr_q  <= wr_word;
            RA_WDATA: wdata_q <= wr_word;
            default:  ;
         endcase
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      word_t q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else if (do_store && in_rng && (idx == IDX_W'(g))) q <= wdata_q;
      end
      assign cells[g] = q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        rdata_q <= '0;
      else if (do_fetch) rdata_q <= in_rng ? cells[idx] : '0;
   end

   always_comb begin
      unique case (rd_reg)
         RA_CTRL:  rd_word = ctrl_q;
         RA_ADDR:  rd_word = addr_q;
         RA_WDATA: rd_word = wdata_q;
         RA_RDATA: rd_word = rdata_q;
         default:  rd_word = '0;
      endcase
   end
endmodule

// File: rtl/mgmt_indirect_bridge.sv
`timescale 1ns/1ps
module mgmt_indirect_bridge
   import mib_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned PRE_MIN     = 32,
   parameter int unsigned DEPTH       = 64,
   parameter logic [15:0] BASE        = 16'h0000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [4:0] phy_addr_strap,
   input  logic       mdc,
   input  logic       mdio_i,
   output logic       mdio_o,
   output logic       mdio_oe
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (PRE_MIN < 1) begin : g_bad_pre
      $error("PRE_MIN must be at least 1");
   end
   if ((DEPTH < 2) || (DEPTH != (1 << $clog2(DEPTH)))) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if ((int'(BASE) + DEPTH) > 65536) begin : g_bad_base
      $error("array window exceeds the internal address space");
   end

   logic   mdc_rise;
   logic   mdc_fall;
   logic   mdio_s;
   field_t cur_reg;
   logic   wr_stb;
   word_t  wr_word;
   logic   phy_hit;
   word_t  rd_word;
   word_t  ctrl_q;
   word_t  rdata_q;

   mib_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .mdc      (mdc),
      .mdio_i   (mdio_i),
      .mdc_rise (mdc_rise),
      .mdc_fall (mdc_fall),
      .mdio_s   (mdio_s)
   );

   mib_frame #(.PRE_MIN(PRE_MIN)) u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .mdc_rise  (mdc_rise),
      .mdc_fall  (mdc_fall),
      .mdio_s    (mdio_s),
      .phy_strap (phy_addr_strap),
      .rd_word   (rd_word),
      .cur_reg   (cur_reg),
      .wr_stb    (wr_stb),
      .wr_word   (wr_word),
      .phy_hit   (phy_hit),
      .mdio_o    (mdio_o),
      .mdio_oe   (mdio_oe)
   );

   mib_regs #(.DEPTH(DEPTH), .BASE(BASE)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_stb  (wr_stb),
      .wr_reg  (cur_reg),
      .wr_word (wr_word),
      .rd_reg  (cur_reg),
      .rd_word (rd_word),
      .ctrl_q  (ctrl_q),
      .rdata_q (rdata_q)
   );
endmodule

// File: rtl/mib_chk.sv
`timescale 1ns/1ps
module mib_chk
   import mib_pkg::*;
(
   input logic   clk,
   input logic   rst_n,
   input logic   mdc_fall,
   input logic   mdio_o,
   input logic   mdio_oe,
   input logic   phy_hit,
   input logic   wr_stb,
   input field_t cur_reg,
   input word_t  wr_word,
   input word_t  ctrl_q,
   input word_t  rdata_q
);
   AST_OE_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !mdc_fall |=> $stable(mdio_oe)); // R3
   AST_BIT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      !mdc_fall |=> $stable(mdio_o)); // R3
   AST_DRIVE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> phy_hit); // R1
   AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_stb && cur_reg == RA_CMD && wr_word == CMD_FETCH && ctrl_q == ARM_CODE)
      |=> $stable(rdata_q)); // R9
   AST_DISARMED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && cur_reg == RA_CMD && ctrl_q != ARM_CODE) |=> $stable(rdata_q)); // R7
endmodule

bind mgmt_indirect_bridge mib_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .mdc_fall (mdc_fall),
   .mdio_o   (mdio_o),
   .mdio_oe  (mdio_oe),
   .phy_hit  (phy_hit),
   .wr_stb   (wr_stb),
   .cur_reg  (cur_reg),
   .wr_word  (wr_word),
   .ctrl_q   (ctrl_q),
   .rdata_q  (rdata_q)
);

// File: tb/mgmt_indirect_bridge_test.sv
`timescale 1ns/1ps
module mgmt_indirect_bridge_test;
   localparam int HALF = 8;
   localparam int WD   = 190000;
   localparam logic [4:0] PHY = 5'h0B;
   localparam int NV = 17;
   // entry: {is_read, reg[4:0], value[15:0]}  value = write data or expected read
   localparam logic [21:0] VEC [NV] = '{
      {1'b0, 5'd31, 16'h000E}, {1'b0, 5'd23, 16'h0005}, {1'b0, 5'd24, 16'hA5A5},
      {1'b0, 5'd21, 16'h0003}, {1'b0, 5'd24, 16'h0000}, {1'b0, 5'd21, 16'h0001},
      {1'b1, 5'd25, 16'hA5A5}, {1'b1, 5'd31, 16'h000E}, {1'b1, 5'd23, 16'h0005},
      {1'b1, 5'd24, 16'h0000}, {1'b0, 5'd23, 16'h003F}, {1'b0, 5'd24, 16'h5AC3},
      {1'b0, 5'd21, 16'h0003}, {1'b0, 5'd21, 16'h0001}, {1'b1, 5'd25, 16'h5AC3},
      {1'b1, 5'd21, 16'h0000}, {1'b1, 5'd7,  16'h0000}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mdc = 1'b0;
   logic st_oe = 1'b0;
   logic st_bit = 1'b1;
   logic mdio_o, mdio_oe, line;
   logic oe_at_sample = 1'b0;
   int   checks = 0;
   int   fails = 0;
   int   clash = 0;
   bit   done = 0;

   always #2.5 clk = ~clk;

   assign line = mdio_oe ? mdio_o : (st_oe ? st_bit : 1'b1);

   mgmt_indirect_bridge uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .phy_addr_strap (PHY),
      .mdc            (mdc),
      .mdio_i         (line),
      .mdio_o         (mdio_o),
      .mdio_oe        (mdio_oe)
   );

   always @(negedge clk) if (mdio_oe && st_oe) clash++;

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic mdio_bit(input logic b, input logic drive, output logic seen);
      mdc = 1'b0; st_oe = drive; st_bit = b;
      repeat (HALF) @(posedge clk);
      #1;
      seen = line; oe_at_sample = mdio_oe;
      mdc = 1'b1;
      repeat (HALF) @(posedge clk);
      #1;
   endtask

   task automatic frame(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                        input logic [15:0] wd, input int pre,
                        output logic [15:0] rv, output logic ta_drv);
      logic s;
      logic [13:0] hdr;
      hdr = {2'b01, (rd ? 2'b10 : 2'b01), phy, ra};
      for (int i = 0; i < pre; i++) mdio_bit(1'b1, 1'b1, s);
      for (int i = 13; i >= 0; i--) mdio_bit(hdr[i], 1'b1, s);
      ta_drv = 1'b0;
      for (int i = 0; i < 2; i++) begin
         if (rd) begin
            mdio_bit(1'b1, 1'b0, s);
            ta_drv = ta_drv | oe_at_sample;
         end else begin
            mdio_bit(i == 0, 1'b1, s);
         end
      end
      for (int i = 15; i >= 0; i--) begin
         mdio_bit(wd[i], !rd, s);
         rv[i] = s;
      end
      mdio_bit(1'b1, 1'b0, s);
   endtask

   task automatic wr(input logic [4:0] ra, input logic [15:0] v);
      logic [15:0] d; logic t;
      frame(1'b0, PHY, ra, v, 32, d, t);
   endtask

   task automatic rd_chk(input logic [4:0] ra, input logic [15:0] exp, input string tag);
      logic [15:0] d; logic t;
      frame(1'b1, PHY, ra, 16'h0000, 32, d, t);
      check(tag, d, exp);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog: actual expired expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] d;
      logic t;
      repeat (5) @(posedge clk);
      #1;
      check("R11 line released in reset", {15'd0, mdio_oe}, 16'h0000);
      rst_n = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      check("R11 line released after reset", {15'd0, mdio_oe}, 16'h0000);
      rd_chk(5'd31, 16'h0000, "R11 arm register reset");
      rd_chk(5'd25, 16'h0000, "R11 result register reset");

      // table walk: R4 R5 R6 R8 R10
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][21]) begin
            frame(1'b1, PHY, VEC[i][20:16], 16'h0000, 32, d, t);
            check($sformatf("table[%0d] R4 R5 R6 R8 R10", i), d, VEC[i][15:0]);
            check($sformatf("table[%0d] R3 turnaround released", i), {15'd0, t}, 16'h0000);
         end else begin
            wr(VEC[i][20:16], VEC[i][15:0]);
         end
      end
      check("R3 line released after reply", {15'd0, mdio_oe}, 16'h0000);

      // R1: foreign PHY address
      frame(1'b1, PHY ^ 5'h01, 5'd31, 16'h0000, 32, d, t);
      check("R1 foreign read floats high", d, 16'hFFFF);
      frame(1'b0, PHY ^ 5'h10, 5'd24, 16'h1234, 32, d, t);
      rd_chk(5'd24, 16'h5AC3, "R1 foreign write ignored");

      // R2: short preamble ignored
      frame(1'b0, PHY, 5'd31, 16'h0000, 20, d, t);
      rd_chk(5'd31, 16'h000E, "R2 short preamble ignored");

      // R7: disarmed commands
      wr(5'd31, 16'h0000);
      wr(5'd23, 16'h0005);
      wr(5'd24, 16'h1111);
      wr(5'd21, 16'h0003);
      wr(5'd21, 16'h0001);
      wr(5'd31, 16'h000E);
      rd_chk(5'd25, 16'h5AC3, "R7 disarmed fetch ignored");
      wr(5'd21, 16'h0001);
      rd_chk(5'd25, 16'hA5A5, "R7 disarmed store ignored");

      // R7: unknown command value
      wr(5'd24, 16'h2222);
      wr(5'd21, 16'h0002);
      rd_chk(5'd25, 16'hA5A5, "R7 unknown command no fetch");
      wr(5'd21, 16'h0001);
      rd_chk(5'd25, 16'hA5A5, "R7 unknown command no store");

      // R8: out of range store and fetch, no aliasing onto index 0
      wr(5'd23, 16'h0040);
      wr(5'd24, 16'h7777);
      wr(5'd21, 16'h0003);
      wr(5'd21, 16'h0001);
      rd_chk(5'd25, 16'h0000, "R8 out of range fetch");
      wr(5'd23, 16'h0000);
      wr(5'd21, 16'h0001);
      rd_chk(5'd25, 16'h0000, "R8 out of range store dropped");

      // R9: result stays through unrelated traffic
      wr(5'd23, 16'h003F);
      wr(5'd24, 16'h9999);
      rd_chk(5'd25, 16'h0000, "R9 result held");
      rd_chk(5'd25, 16'h0000, "R9 result held on reread");

      check("R3 no drive contention", clash[15:0], 16'h0000);
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule